// File: doc/BRIEF.md
# Inclusive Shared-Cache Presence Directory

This block holds the tags and the per-core presence state of a set-associative last-level cache shared by several private per-core caches. Inclusion is strict: a line can sit in a private cache only while the shared cache also holds it. Each cached line carries one presence bit per core. A set bit means that core *may* hold the line, and bits left set after a silent private eviction are harmless. Because of inclusion, a lookup that misses here goes straight to the fill path and never probes any core.

A core presents a lookup with its core number, a read-or-ownership flag and a line address. The low address bits pick the set and the high bits form the tag. On a hit, the cores flagged in the line's presence bits are probed, except the requester. An ownership hit also invalidates those cores, and their bits are dropped once they acknowledge. On a miss, a victim way is chosen. If the victim still has flagged cores, they are sent back-invalidations and must all acknowledge before the downstream fill request is raised. The probe/acknowledge and fill/acknowledge channels stand in for the private caches and the memory side. One lookup is in flight at a time.

Top module: `llc_presence_dir`

## Requirements
- R1: After reset, `req_ready` stays low for exactly SETS cycles while every set is cleared. After that, every line is invalid and every victim tree is all zeros, so the first lookup to any address misses.
- R2: A miss responds with `resp_hit`=0 and raises no probe to any core other than a back-invalidation. It raises `fill_req_valid` with `fill_req_addr` equal to the request address, holds both steady until `fill_ack`, and responds in the cycle after the acknowledge.
- R3: A read hit on a line whose presence bits name no core other than the requester responds with `resp_hit`=1 and raises no probe and no fill.
- R4: A hit on a line that flags other cores raises a probe with `probe_evict`=0 and `probe_addr` equal to the request address. `probe_inv` is 1 for an ownership request and 0 for a read. The hit response follows completion of the probe.
- R5: The probe mask of a hit equals the line's presence bits with the requester's bit removed. A fill leaves only the requester's bit set. A read hit adds the requester's bit and keeps the others. A completed ownership hit leaves only the requester's bit.
- R6: While `probe_valid` is high, `probe_mask` shows the cores still to acknowledge, and it never gains a bit. A `probe_ack` bit removes that core. Acknowledges from cores not outstanding are ignored. `probe_valid` drops in the cycle after the last outstanding acknowledge.
- R7: The victim is the lowest-numbered invalid way of the set. If every way is valid, a binary tree pseudo-LRU picks it. For 4 ways the tree bits are b0 (root), b1 (ways 0/1) and b2 (ways 2/3), and a bit of 1 points to the upper half. Every hit and every fill sets the bits on the path to the used way to point away from it.
- R8: A valid victim with any presence bit set raises a probe with `probe_evict`=1, `probe_inv`=1, a mask equal to its presence bits and `probe_addr` equal to the victim's line address, and this probe completes before the fill request. A victim with no bits set goes straight to the fill.
- R9: `req_ready` is high only while idle. It stays low from acceptance until the response, `resp_valid` is a one-cycle pulse, and `req_ready` is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block idle and accepting a lookup |
| req_core | input | log2(NUM_CORES) | Requesting core number |
| req_own | input | 1 | 1 = ownership request, 0 = read |
| req_addr | input | TAG_W+log2(SETS) | Line address: set index in low bits, tag above |
| resp_valid | output | 1 | One-cycle lookup completion |
| resp_hit | output | 1 | Lookup hit in the shared cache |
| fill_req_valid | output | 1 | Downstream fill requested |
| fill_req_addr | output | TAG_W+log2(SETS) | Line address to fetch |
| fill_ack | input | 1 | Fill data delivered |
| probe_valid | output | 1 | Probe to private caches outstanding |
| probe_mask | output | NUM_CORES | Cores still to acknowledge |
| probe_inv | output | 1 | Probe invalidates the private copy |
| probe_evict | output | 1 | Probe is a back-invalidation of a victim |
| probe_addr | output | TAG_W+log2(SETS) | Line address being probed |
| probe_ack | input | NUM_CORES | Per-core probe acknowledge pulses |

## Verification
The hardest state to reach is a back-invalidation of a victim that several cores still flag, followed by an immediate refill of the same set. It needs a full set, a specific tree-LRU state and a line that was read by more than one core. The bench reaches it with a pseudo-random sweep over a four-set, four-way configuration with eight tags per set, so sets overflow constantly while cores share and claim lines. It mirrors the tag, presence and tree state arithmetically to predict every probe mask, victim address and fill. Each probe also receives a stray acknowledge from an uninvolved core and then real acknowledges in alternating order.

// File: rtl/llc_dir_pkg.sv
package llc_dir_pkg;

   typedef enum logic [2:0] {
      ST_INIT,
      ST_IDLE,
      ST_LOOK,
      ST_PROBE,
      ST_FILL,
      ST_RESP
   } dir_state_e;

endpackage

// File: rtl/llc_ack_collect.sv
// Tracks which cores still owe a probe acknowledge.
module llc_ack_collect #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [NUM_CORES-1:0] load_mask,
   input  logic [NUM_CORES-1:0] ack,
   output logic [NUM_CORES-1:0] pending,
   output logic                 last
);

   logic [NUM_CORES-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend_q <= '0;
      else if (load) pend_q <= load_mask;
      else           pend_q <= pend_q & ~ack;
   end

   assign pending = pend_q;
   assign last    = (pend_q != '0) && ((pend_q & ~ack) == '0);

endmodule

// File: rtl/llc_plru.sv
// Per-set binary-tree pseudo-LRU state with victim read and touch update.
module llc_plru #(
   parameter int SETS = 64,
   parameter int WAYS = 4
) (
   input  logic                    clk,
   input  logic                    clr_en,
   input  logic [$clog2(SETS)-1:0] clr_set,
   input  logic [$clog2(SETS)-1:0] rd_set,
   output logic [$clog2(WAYS)-1:0] victim,
   input  logic                    touch_en,
   input  logic [$clog2(SETS)-1:0] touch_set,
   input  logic [$clog2(WAYS)-1:0] touch_way
);

   localparam int WAY_W = $clog2(WAYS);
   localparam int NODES = WAYS - 1;

   generate
      if (WAYS == 2) begin : g_pair
         logic lru_q [SETS];
         always_ff @(posedge clk) begin
            if (clr_en)        lru_q[clr_set]   <= 1'b0;
            else if (touch_en) lru_q[touch_set] <= ~touch_way[0];
         end
         assign victim = lru_q[rd_set];
      end else begin : g_tree
         logic [NODES-1:0] tree_q [SETS];
         logic [NODES-1:0] tree_nxt;

         always_comb begin
            int node;
            node   = 0;
            victim = '0;
            for (int l = 0; l < WAY_W; l++) begin
               victim = (victim << 1) | WAY_W'(tree_q[rd_set][node]);
               node   = 2 * node + 1 + int'(tree_q[rd_set][node]);
            end
         end

         always_comb begin
            int node;
            node     = 0;
            tree_nxt = tree_q[touch_set];
            for (int l = 0; l < WAY_W; l++) begin
               tree_nxt[node] = ~touch_way[WAY_W-1-l];
               node = 2 * node + 1 + int'(touch_way[WAY_W-1-l]);
            end
         end

         always_ff @(posedge clk) begin
            if (clr_en)        tree_q[clr_set]   <= '0;
            else if (touch_en) tree_q[touch_set] <= tree_nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/llc_presence_dir.sv
module llc_presence_dir
   import llc_dir_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int SETS      = 64,
   parameter int WAYS      = 4,
   parameter int TAG_W     = 10
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  req_valid,
   output logic                                  req_ready,
   input  logic [$clog2(NUM_CORES)-1:0]          req_core,
   input  logic                                  req_own,
   input  logic [TAG_W+$clog2(SETS)-1:0]         req_addr,
   output logic                                  resp_valid,
   output logic                                  resp_hit,
   output logic                                  fill_req_valid,
   output logic [TAG_W+$clog2(SETS)-1:0]         fill_req_addr,
   input  logic                                  fill_ack,
   output logic                                  probe_valid,
   output logic [NUM_CORES-1:0]                  probe_mask,
   output logic                                  probe_inv,
   output logic                                  probe_evict,
   output logic [TAG_W+$clog2(SETS)-1:0]         probe_addr,
   input  logic [NUM_CORES-1:0]                  probe_ack
);

   localparam int IDX_W  = $clog2(SETS);
   localparam int WAY_W  = $clog2(WAYS);
   localparam int CORE_W = $clog2(NUM_CORES);
   localparam int ADDR_W = TAG_W + IDX_W;

   generate
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("SETS must be a power of two, at least 2");
      end
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("WAYS must be a power of two, at least 2");
      end
      if (NUM_CORES < 2) begin : g_bad_cores
         $error("NUM_CORES must be at least 2");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("TAG_W must be at least 1");
      end
   endgenerate

   dir_state_e           state_q;
   logic [IDX_W-1:0]     init_set_q;
   logic [CORE_W-1:0]    core_q;
   logic                 own_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [WAY_W-1:0]     way_q;
   logic                 hit_q;
   logic                 evict_q;
   logic [ADDR_W-1:0]    paddr_q;

   logic [WAYS-1:0]      vld_q  [SETS];
   logic [TAG_W-1:0]     tag_q  [SETS][WAYS];
   logic [NUM_CORES-1:0] pres_q [SETS][WAYS];

   logic [IDX_W-1:0]     idx;
   logic [TAG_W-1:0]     tag;
   logic [NUM_CORES-1:0] me;
   logic                 hit_any, free_any;
   logic [WAY_W-1:0]     hit_way, free_way, lru_way, vic_way;
   logic [NUM_CORES-1:0] others, vic_pres;
   logic                 ack_load, ack_last, touch_en;
   logic [NUM_CORES-1:0] pending;
   logic [WAY_W-1:0]     touch_way;

   assign idx = addr_q[IDX_W-1:0];
   assign tag = addr_q[ADDR_W-1:IDX_W];
   assign me  = NUM_CORES'(1) << core_q;

   // Tag compare and first-free search over the selected set.
   always_comb begin
      hit_any  = 1'b0;
      hit_way  = '0;
      free_any = 1'b0;
      free_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (vld_q[idx][w] && tag_q[idx][w] == tag && !hit_any) begin
            hit_any = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!vld_q[idx][w]) begin
            free_any = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end

   assign vic_way  = free_any ? free_way : lru_way;
   assign others   = pres_q[idx][hit_way] & ~me;
   assign vic_pres = vld_q[idx][vic_way] ? pres_q[idx][vic_way] : '0;

   assign ack_load = (state_q == ST_LOOK) &&
                     (hit_any ? (others != '0) : (vic_pres != '0));

   llc_ack_collect #(.NUM_CORES(NUM_CORES)) u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ack_load),
      .load_mask (hit_any ? others : vic_pres),
      .ack       (probe_ack),
      .pending   (pending),
      .last      (ack_last)
   );

   assign touch_en  = (state_q == ST_LOOK && hit_any && others == '0) ||
                      (state_q == ST_PROBE && ack_last && !evict_q) ||
                      (state_q == ST_FILL && fill_ack);
   assign touch_way = (state_q == ST_LOOK) ? hit_way : way_q;

   llc_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
      .clk       (clk),
      .clr_en    (state_q == ST_INIT),
      .clr_set   (init_set_q),
      .rd_set    (idx),
      .victim    (lru_way),
      .touch_en  (touch_en),
      .touch_set (idx),
      .touch_way (touch_way)
   );

   // Sequencing of one lookup at a time.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_INIT;
         init_set_q <= '0;
         core_q     <= '0;
         own_q      <= 1'b0;
         addr_q     <= '0;
         way_q      <= '0;
         hit_q      <= 1'b0;
         evict_q    <= 1'b0;
         paddr_q    <= '0;
      end else begin
         case (state_q)
            ST_INIT: begin
               init_set_q <= init_set_q + 1'b1;
               if (init_set_q == IDX_W'(SETS - 1)) state_q <= ST_IDLE;
            end
            ST_IDLE: if (req_valid) begin
               core_q  <= req_core;
               own_q   <= req_own;
               addr_q  <= req_addr;
               state_q <= ST_LOOK;
            end
            ST_LOOK: begin
               hit_q <= hit_any;
               if (hit_any) begin
                  way_q   <= hit_way;
                  evict_q <= 1'b0;
                  paddr_q <= addr_q;
                  state_q <= (others != '0) ? ST_PROBE : ST_RESP;
               end else begin
                  way_q   <= vic_way;
                  evict_q <= 1'b1;
                  paddr_q <= {tag_q[idx][vic_way], idx};
                  state_q <= (vic_pres != '0) ? ST_PROBE : ST_FILL;
               end
            end
            ST_PROBE: if (ack_last) state_q <= evict_q ? ST_FILL : ST_RESP;
            ST_FILL:  if (fill_ack) state_q <= ST_RESP;
            ST_RESP:  state_q <= ST_IDLE;
            default:  state_q <= ST_INIT;
         endcase
      end
   end

   // Tag, valid and presence arrays; cleared a set per cycle during init.
   always_ff @(posedge clk) begin
      if (state_q == ST_INIT) begin
         vld_q[init_set_q] <= '0;
         for (int w = 0; w < WAYS; w++) pres_q[init_set_q][w] <= '0;
      end else if (state_q == ST_LOOK && hit_any && others == '0) begin
         pres_q[idx][hit_way] <= pres_q[idx][hit_way] | me;
      end else if (state_q == ST_PROBE && ack_last) begin
         if (evict_q) begin
            vld_q[idx][way_q]  <= 1'b0;
            pres_q[idx][way_q] <= '0;
         end else begin
            pres_q[idx][way_q] <= own_q ? me : (pres_q[idx][way_q] | me);
         end
      end else if (state_q == ST_FILL && fill_ack) begin
         tag_q[idx][way_q]  <= tag;
         vld_q[idx][way_q]  <= 1'b1;
         pres_q[idx][way_q] <= me;
      end
   end

   assign req_ready      = (state_q == ST_IDLE);
   assign resp_valid     = (state_q == ST_RESP);
   assign resp_hit       = hit_q;
   assign fill_req_valid = (state_q == ST_FILL);
   assign fill_req_addr  = addr_q;
   assign probe_valid    = (state_q == ST_PROBE);
   assign probe_mask     = pending;
   assign probe_inv      = evict_q | own_q;
   assign probe_evict    = evict_q;
   assign probe_addr     = paddr_q;

endmodule

// File: rtl/llc_presence_dir_chk.sv
module llc_presence_dir_chk #(
   parameter int NUM_CORES = 4,
   parameter int SETS      = 64,
   parameter int TAG_W     = 10
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              req_ready,
   input logic                              resp_valid,
   input logic                              resp_hit,
   input logic                              fill_req_valid,
   input logic [TAG_W+$clog2(SETS)-1:0]     fill_req_addr,
   input logic                              fill_ack,
   input logic                              probe_valid,
   input logic [NUM_CORES-1:0]              probe_mask,
   input logic                              probe_evict,
   input logic [$clog2(NUM_CORES)-1:0]      cur_core
);

   logic [31:0] init_cnt;
   logic        snoop_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) init_cnt <= '0;
      else if (init_cnt != 32'hFFFF_FFFF) init_cnt <= init_cnt + 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          snoop_seen <= 1'b0;
      else if (resp_valid)                 snoop_seen <= 1'b0;
      else if (probe_valid && !probe_evict) snoop_seen <= 1'b1;
   end

   a_r1_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (init_cnt < 32'(SETS)) |-> !req_ready);

   a_r2_miss_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> !snoop_seen);

   a_r2_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req_valid && !fill_ack) |=> (fill_req_valid && $stable(fill_req_addr)));

   a_r5_skip_requester: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_valid && !probe_evict) |-> ((probe_mask & (NUM_CORES'(1) << cur_core)) == '0));

   a_r6_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid |-> (probe_mask != '0));

   a_r6_mask_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid |=> (!probe_valid || ((probe_mask & ~$past(probe_mask)) == '0)));

   a_r8_probe_before_fill: assert property (@(posedge clk) disable iff (!rst_n)
      !(probe_valid && fill_req_valid));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!probe_valid && !fill_req_valid && !resp_valid));

   a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

endmodule

bind llc_presence_dir llc_presence_dir_chk #(
   .NUM_CORES (NUM_CORES),
   .SETS      (SETS),
   .TAG_W     (TAG_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_ready      (req_ready),
   .resp_valid     (resp_valid),
   .resp_hit       (resp_hit),
   .fill_req_valid (fill_req_valid),
   .fill_req_addr  (fill_req_addr),
   .fill_ack       (fill_ack),
   .probe_valid    (probe_valid),
   .probe_mask     (probe_mask),
   .probe_evict    (probe_evict),
   .cur_core       (core_q)
);

// File: tb/llc_presence_dir_tb.sv
module llc_presence_dir_tb;

   localparam int NC     = 4;
   localparam int SETS   = 4;
   localparam int WAYS   = 4;
   localparam int TAG_W  = 3;
   localparam int IDX_W  = 2;
   localparam int ADDR_W = TAG_W + IDX_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [1:0]        req_core = '0;
   logic              req_own = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              resp_valid, resp_hit;
   logic              fill_req_valid;
   logic [ADDR_W-1:0] fill_req_addr;
   logic              fill_ack = 1'b0;
   logic              probe_valid, probe_inv, probe_evict;
   logic [NC-1:0]     probe_mask;
   logic [ADDR_W-1:0] probe_addr;
   logic [NC-1:0]     probe_ack = '0;

   int n_chk  = 0;
   int n_fail = 0;

   logic             m_vld  [SETS][WAYS];
   logic [TAG_W-1:0] m_tag  [SETS][WAYS];
   logic [NC-1:0]    m_pres [SETS][WAYS];
   logic [2:0]       m_plru [SETS];

   always #10 clk = ~clk;

   llc_presence_dir #(.NUM_CORES(NC), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_core(req_core), .req_own(req_own), .req_addr(req_addr),
      .resp_valid(resp_valid), .resp_hit(resp_hit),
      .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr), .fill_ack(fill_ack),
      .probe_valid(probe_valid), .probe_mask(probe_mask), .probe_inv(probe_inv),
      .probe_evict(probe_evict), .probe_addr(probe_addr), .probe_ack(probe_ack)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int victim4(input logic [2:0] b);
      if (!b[0]) return b[1] ? 1 : 0;
      return b[2] ? 3 : 2;
   endfunction

   function automatic logic [2:0] touch4(input logic [2:0] b, input int w);
      logic [2:0] n;
      n = b;
      n[0] = (w < 2);
      if (w < 2) n[1] = (w == 0);
      else       n[2] = (w == 2);
      return n;
   endfunction

   function automatic logic [NC-1:0] pick(input logic [NC-1:0] m, input bit hi);
      if (hi) begin
         for (int i = NC - 1; i >= 0; i--) if (m[i]) return NC'(1) << i;
      end else begin
         for (int i = 0; i < NC; i++) if (m[i]) return NC'(1) << i;
      end
      return '0;
   endfunction

   task automatic run_txn(input int core, input bit own, input logic [ADDR_W-1:0] addr,
                          input bit hi_first);
      int               idx, hw, way, pcyc, fcyc, n_need;
      logic [TAG_W-1:0] tg;
      logic [NC-1:0]    me, e_mask, spur, a_mask;
      logic [ADDR_W-1:0] e_paddr, a_paddr, a_faddr;
      bit e_hit, e_probe, e_inv, e_evict, e_fill;
      bit got_probe, got_fill, got_resp, a_hit, a_inv, a_evict, busy_ok, fill_stable, mask_ok;

      idx = int'(addr[IDX_W-1:0]);
      tg  = addr[ADDR_W-1:IDX_W];
      me  = NC'(1) << core;
      hw  = -1;
      for (int w = 0; w < WAYS; w++) if (m_vld[idx][w] && m_tag[idx][w] == tg && hw < 0) hw = w;
      if (hw >= 0) begin
         e_hit = 1; way = hw; e_mask = m_pres[idx][hw] & ~me;
         e_inv = own; e_evict = 0; e_paddr = addr; e_fill = 0;
         spur = me;
      end else begin
         e_hit = 0; way = -1;
         for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[idx][w]) way = w;
         if (way < 0) way = victim4(m_plru[idx]);
         e_mask = m_vld[idx][way] ? m_pres[idx][way] : '0;
         e_inv = 1; e_evict = 1; e_paddr = {m_tag[idx][way], idx[IDX_W-1:0]}; e_fill = 1;
         spur = pick(~e_mask, 1'b0);
      end
      e_probe = (e_mask != '0);
      n_need  = $countones(e_mask);

      @(negedge clk);
      req_valid = 1'b1; req_core = 2'(core); req_own = own; req_addr = addr;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;

      got_probe = 0; got_fill = 0; got_resp = 0; busy_ok = 1; fill_stable = 1; mask_ok = 1;
      pcyc = 0; fcyc = 0; a_hit = 0; a_inv = 0; a_evict = 0;
      a_mask = '0; a_paddr = '0; a_faddr = '0;
      for (int cyc = 0; cyc < 300 && !got_resp; cyc++) begin
         probe_ack = '0;
         fill_ack  = 1'b0;
         if (req_ready) busy_ok = 0;
         if (probe_valid) begin
            if (pcyc == 0) begin
               got_probe = 1; a_mask = probe_mask; a_inv = probe_inv;
               a_evict = probe_evict; a_paddr = probe_addr;
               probe_ack = spur;
            end else begin
               if (pcyc == 1 && probe_mask != a_mask) mask_ok = 0;
               probe_ack = pick(probe_mask, hi_first);
            end
            pcyc++;
         end
         if (fill_req_valid) begin
            if (fcyc == 0) a_faddr = fill_req_addr;
            else if (fill_req_addr != a_faddr) fill_stable = 0;
            if (fcyc >= 1) fill_ack = 1'b1;
            fcyc++;
            got_fill = 1;
         end
         if (resp_valid) begin
            got_resp = 1;
            a_hit = resp_hit;
         end else begin
            @(negedge clk);
         end
      end
      probe_ack = '0;
      fill_ack  = 1'b0;

      check(got_resp, "R9 response arrives", int'(got_resp), 1);
      check(a_hit == e_hit, e_hit ? "R3 hit reported" : "R2 miss reported", int'(a_hit), int'(e_hit));
      check(got_probe == e_probe, e_evict ? "R8 back-invalidation presence" : "R4 snoop presence",
            int'(got_probe), int'(e_probe));
      if (got_probe && e_probe) begin
         check(a_mask == e_mask, e_evict ? "R8 victim mask" : "R5 snoop mask",
               int'(a_mask), int'(e_mask));
         check(a_inv == e_inv, e_evict ? "R8 inv flag" : "R4 inv flag", int'(a_inv), int'(e_inv));
         check(a_evict == e_evict, "R8 evict flag", int'(a_evict), int'(e_evict));
         check(a_paddr == e_paddr, e_evict ? "R7 victim address" : "R4 probe address",
               int'(a_paddr), int'(e_paddr));
         check(mask_ok, "R6 stray ack ignored", int'(mask_ok), 1);
         check(pcyc == n_need + 1, "R6 probe length", pcyc, n_need + 1);
      end
      check(got_fill == e_fill, "R2 fill presence", int'(got_fill), int'(e_fill));
      if (got_fill) begin
         check(a_faddr == addr, "R2 fill address", int'(a_faddr), int'(addr));
         check(fill_stable, "R2 fill held", int'(fill_stable), 1);
      end
      check(busy_ok, "R9 ready low while busy", int'(busy_ok), 1);

      @(negedge clk);
      check(!resp_valid && req_ready, "R9 resp pulse then ready",
            int'({resp_valid, req_ready}), 1);

      if (e_hit) m_pres[idx][way] = own ? me : (m_pres[idx][way] | me);
      else begin
         m_vld[idx][way] = 1'b1; m_tag[idx][way] = tg; m_pres[idx][way] = me;
      end
      m_plru[idx] = touch4(m_plru[idx], way);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n_low;
      logic [15:0] lfsr;
      for (int s = 0; s < SETS; s++) begin
         m_plru[s] = '0;
         for (int w = 0; w < WAYS; w++) begin
            m_vld[s][w] = 1'b0; m_tag[s][w] = '0; m_pres[s][w] = '0;
         end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      n_low = 0;
      while (!req_ready) begin
         n_low++;
         @(negedge clk);
      end
      check(n_low == SETS, "R1 init cycles", n_low, SETS);

      // Shared line, then ownership, then re-read by another core.
      for (int c = 0; c < NC; c++) run_txn(c, 1'b0, 5'b001_00, c[0]);
      run_txn(2, 1'b1, 5'b001_00, 1'b1);
      run_txn(0, 1'b0, 5'b001_00, 1'b0);
      run_txn(0, 1'b0, 5'b001_00, 1'b0);
      // Fill set 1 with shared lines and overflow it.
      for (int t = 0; t < 6; t++) begin
         run_txn(t % NC, 1'b0, {3'(t), 2'b01}, t[0]);
         run_txn((t + 1) % NC, 1'b0, {3'(t), 2'b01}, t[1]);
      end

      lfsr = 16'hACE1;
      for (int n = 0; n < 700; n++) begin
         lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
         lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
         run_txn(int'(lfsr[1:0]), (lfsr[4:2] == 3'd0), {lfsr[9:7], lfsr[6:5]}, lfsr[11]);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule